// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block joins two parallel buses, side A and side B, through two independent non-inverting paths, A-to-B and B-to-A. Each path holds one storage bit per data bit. Three controls decide how that storage behaves:

- With its latch-enable high, a path is transparent. The far side follows the near side in the same cycle.
- With latch-enable low, the storage holds its value.
- With latch-enable low, a rising edge on the path's capture strobe loads the current input.

Each path has its own output enable. The A-to-B enable is active-high and the B-to-A enable is active-low.

Storage keeps updating while the outputs are disabled. A word can therefore be loaded while the bus is floating and shown later.

The core is meant for synthesis. Each side is split into a data-in vector, a data-out vector and a per-bit drive-enable vector. A pad ring combines these into true three-state pins.

The capture strobes and latch enables are sampled on the block clock `clk`. A strobe edge is a strobe sample that is high after a low one. An active-low asynchronous reset clears both storage arrays and holds every drive enable low. Power-up therefore gives a floating bus whatever level the enable pins have.

Top module: `txv_top`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R2: While `ab_le` is 0 and `ab_cp` shows no rising edge, the A-to-B storage keeps its value, whatever `a_in` does.
- R3: While `ab_le` is 0, a sampled rise of `ab_cp` (0 at one clk edge, 1 at the next) loads `a_in` at that edge. The new value shows on `b_out` right after that edge.
- R4: When `ab_le` falls, the storage keeps the value `a_in` had at the last clk edge at which `ab_le` was still 1. If `ab_cp` rises at the same edge where `ab_le` is first seen low, the current `a_in` is loaded, and it is the same data when `a_in` has not changed.
- R5: `b_oe` is all ones when `ab_oe` is 1 and all zeros when it is 0 (bit i of `b_oe` enables bit i of the B pins).
- R6: `a_oe` is all ones when `ba_oe_n` is 0 and all zeros when it is 1.
- R7: The B-to-A path behaves as R1 to R4, using `ba_le`, `ba_cp`, `b_in` and `a_out`.
- R8: Transparent, latched and strobed loads all update the storage while the outputs are disabled. A later enable shows the loaded word.
- R9: While `rst_n` is 0, both storage arrays read zero and `a_oe` and `b_oe` are all zeros, whatever the enables are.
- R10: A strobe held high across reset release does not count as a rising edge. Only a later low-to-high change loads data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples strobes, latch enables and data |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data seen on the A pins |
| a_out | output | W | Data driven onto the A pins |
| a_oe | output | W | Per-bit drive enable for the A pins |
| b_in | input | W | Data seen on the B pins |
| b_out | output | W | Data driven onto the B pins |
| b_oe | output | W | Per-bit drive enable for the B pins |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cp | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_cp | input | 1 | B-to-A capture strobe |

## Verification
Transparent data, drive enables and the reset clamp are combinational, so their checks sample one time step after the inputs change at the falling clk edge. A strobed or latched load is registered once. Its result is due right after the rising edge that sees the strobe high, or that last sees the latch enable high. The bench changes stimulus at a falling edge, waits one rising edge, and checks at the next falling edge, after first changing the input so that a held value cannot be mistaken for a transparent one. Each mode (disabled with latch, disabled with strobe, transparent, latch and display, strobe and display, hold and display) is run in both directions over a sweep of patterns.

// File: rtl/txv_pkg.sv
package txv_pkg;
  typedef enum logic [1:0] {
    ST_KEEP   = 2'd0,
    ST_FOLLOW = 2'd1,
    ST_LOAD   = 2'd2
  } st_act_t;
endpackage

// File: rtl/txv_cpedge.sv
module txv_cpedge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  // Reset to 1 so a strobe held high across reset release is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/txv_store.sv
module txv_store
  import txv_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  st_act_t      act,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (act)
        ST_FOLLOW, ST_LOAD: q <= din;
        default:            q <= q;
      endcase
    end
  end
endmodule

// File: rtl/txv_lane.sv
module txv_lane
  import txv_pkg::*;
#(
  parameter int W = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         cp,
  input  logic         oe_pin,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe_vec
);
  logic         rise;
  st_act_t      act;
  logic [W-1:0] held;
  logic         drive;

  txv_cpedge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(cp),
    .rise  (rise)
  );

  always_comb begin
    if (le)        act = ST_FOLLOW;
    else if (rise) act = ST_LOAD;
    else           act = ST_KEEP;
  end

  txv_store #(.W(W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .act  (act),
    .din  (din),
    .q    (held)
  );

  generate
    if (OE_LOW) begin : g_oe_low
      assign drive = ~oe_pin;
    end else begin : g_oe_high
      assign drive = oe_pin;
    end
  endgenerate

  // While in reset the storage reads zero and the pins float.
  assign dout   = (le && rst_n) ? din : held;
  assign oe_vec = {W{drive & rst_n}};
endmodule

// File: rtl/txv_top.sv
module txv_top #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_cp,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_cp
);
  txv_lane #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (a_in),
    .le    (ab_le),
    .cp    (ab_cp),
    .oe_pin(ab_oe),
    .dout  (b_out),
    .oe_vec(b_oe)
  );

  txv_lane #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (b_in),
    .le    (ba_le),
    .cp    (ba_cp),
    .oe_pin(ba_oe_n),
    .dout  (a_out),
    .oe_vec(a_oe)
  );
endmodule

// File: rtl/txv_chk.sv
module txv_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         ab_oe,
  input logic         ab_le,
  input logic         ab_cp,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_cp
);
  always_comb begin
    if (rst_n == 1'b0) begin
      AST_RESET_FLOAT: assert (a_oe == '0 && b_oe == '0); // R9
    end
  end

  AST_AB_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ab_le) && !ab_le && $past(rst_n)) |-> b_out == $past(a_in)); // R4

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !(ab_cp && !$past(ab_cp))) |=> (ab_le || b_out == $past(b_out))); // R2

  AST_AB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_cp && !$past(ab_cp) && $past(rst_n)) |=> (ab_le || b_out == $past(a_in))); // R3

  AST_BA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && ba_cp && !$past(ba_cp) && $past(rst_n)) |=> (ba_le || a_out == $past(b_in))); // R7

  AST_OE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_oe == b_oe[0]) && (ba_oe_n != a_oe[0]) && ($countones(b_oe) == 0 || $countones(b_oe) == W)); // R5
endmodule

bind txv_top txv_chk #(.W(W)) u_txv_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_oe(ab_oe), .ab_le(ab_le),
  .ab_cp(ab_cp), .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp)
);

// File: tb/test_txv_top.sv
module test_txv_top;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ab_oe = 1'b1, ab_le = 1'b0, ab_cp = 1'b0;
  logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_cp = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  txv_top #(.W(W)) i_txv_top (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_oe(ab_oe), .ab_le(ab_le),
    .ab_cp(ab_cp), .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 32'h9E3779B1) ^ (i << 5) ^ 32'h2A5A5);
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset: enables asserted but pins float, storage zero.
    ab_cp = 1'b1; ba_cp = 1'b1;
    @(negedge clk); #1;
    chk("R9 b_oe in reset", b_oe, '0);
    chk("R9 a_oe in reset", a_oe, '0);
    chk("R9 b_out in reset", b_out, '0);
    chk("R9 a_out in reset", a_out, '0);
    a_in = pat(1); b_in = pat(2);
    tick();
    rst_n = 1'b1;
    // Strobes held high across release: no load.
    tick(); tick();
    chk("R10 ab no load", b_out, '0);
    chk("R10 ba no load", a_out, '0);
    #1;
    chk("R5 b_oe on", b_oe, ONES);
    chk("R6 a_oe on", a_oe, ONES);
    ab_oe = 1'b0; ba_oe_n = 1'b1; #1;
    chk("R5 b_oe off", b_oe, '0);
    chk("R6 a_oe off", a_oe, '0);
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    ab_cp = 1'b0; ba_cp = 1'b0;

    // Sweep of the modes over patterns in both directions.
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] pa, pb, qa, qb;
      pa = pat(3 * i + 5); pb = pat(7 * i + 11);
      qa = ~pa; qb = ~pb;
      ab_oe = i[0]; ba_oe_n = i[1];
      // transparent
      @(negedge clk);
      ab_le = 1'b1; ba_le = 1'b1; a_in = qa; b_in = qb; #1;
      chk("R1 transparent", b_out, qa);
      chk("R7 transparent", a_out, qb);
      a_in = pa; b_in = pb; #1;
      chk("R1 follows", b_out, pa);
      chk("R7 follows", a_out, pb);
      tick();
      // close the latch, then change inputs
      ab_le = 1'b0; ba_le = 1'b0;
      tick();
      a_in = qa; b_in = qb;
      tick();
      chk("R4 latch close", b_out, pa);
      chk("R7 latch close", a_out, pb);
      chk("R8 ab oe gate", b_oe, ab_oe ? ONES : '0);
      chk("R6 a_oe level", a_oe, ba_oe_n ? '0 : ONES);
      // strobe load of qa/qb
      ab_cp = 1'b1; ba_cp = 1'b1;
      tick();
      chk("R3 strobe load", b_out, qa);
      chk("R7 strobe load", a_out, qb);
      // strobe stays high, data changes: hold
      a_in = pa; b_in = pb;
      tick();
      chk("R2 hold cp high", b_out, qa);
      chk("R7 hold cp high", a_out, qb);
      ab_cp = 1'b0; ba_cp = 1'b0;
      tick();
      chk("R2 hold cp fall", b_out, qa);
      chk("R7 hold cp fall", a_out, qb);
    end

    // Load while disabled, then display.
    ab_oe = 1'b0; ba_oe_n = 1'b1;
    a_in = pat(90); b_in = pat(91);
    ab_cp = 1'b1; ba_cp = 1'b1;
    tick();
    ab_cp = 1'b0; ba_cp = 1'b0;
    a_in = pat(92); b_in = pat(93);
    tick();
    ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
    chk("R8 ab loaded while off", b_out, pat(90));
    chk("R8 ba loaded while off", a_out, pat(91));
    chk("R8 b_oe after enable", b_oe, ONES);

    // Latch close with simultaneous strobe rise.
    @(negedge clk);
    ab_le = 1'b1; a_in = pat(94);
    tick();
    ab_le = 1'b0; ab_cp = 1'b1;
    tick();
    a_in = pat(95);
    tick();
    chk("R4 close with strobe", b_out, pat(94));
    ab_cp = 1'b0;

    // Reset mid-operation.
    rst_n = 1'b0; #1;
    chk("R9 b_out cleared", b_out, '0);
    chk("R9 b_oe cleared", b_oe, '0);
    chk("R9 a_oe cleared", a_oe, '0);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule